// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Bus

This block is the target side of a two-wire serial control port. It owns a bank of seven 8-bit configuration registers. SCL and SDA are sampled into the fast system clock, so the block needs no clock of its own from the bus. It detects start, repeated start and stop conditions. It checks the 7-bit target address and the direction bit, and it pulls SDA low to acknowledge. Every transfer names a beginning index, so a host can reach any register in one transaction.

A write carries the target address with the write bit, then the beginning index, then a byte count, then data bytes. Data bytes go to consecutive registers. A read sets the index in the same way, then issues a repeated start and the target address with the read bit. The target answers with the stored byte count first, followed by register contents from the index onward. The host acknowledges each byte and ends the read with a not-acknowledge and a stop.

The bus side is a bit-level handshake in which SCL paces every bit. The block never holds SCL low and exerts no back-pressure. The register contents leave on a plain parallel output with no valid/ready pair, because they are static configuration.

Top module: `smb_blkreg`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 0x6A (0xD4 to write, 0xD5 to read). Any other address is not acknowledged, and every later byte is ignored and not acknowledged until the next start condition.
- R2: A block write of index N, count X and data bytes acknowledges every byte. Data byte k is written to register N+k. Bytes beyond X are also written in the same way.
- R3: The count byte of a write is stored. Reads return the stored value, which after reset is 7.
- R4: After a repeated start and the read address, the target sends the stored count and then the registers from the current index upward, most significant bit first, advancing the index after each byte.
- R5: When the host does not acknowledge a byte it has read, the target releases SDA and drives nothing until the next start or stop.
- R6: Each register has a write mask: index 0 mask 0xFF reset 0x1C, 1 mask 0xCC reset 0xCF, 2 mask 0x7F reset 0xFF, 3 mask 0xFF reset 0xFF, 4 mask 0xFF reset 0xFF, 5 mask 0x0F reset 0xFF, 6 mask 0x00 reset 0x21. Bits outside the mask keep their value. `cfg_q` holds register i in bits 8i+7..8i.
- R7: An index of 7 or more reads as 0xFF, and a write to it changes no register.
- R8: A stop at any point ends the transfer and releases SDA. A start at any point, including in the middle of a byte, begins a new address phase.
- R9: The target changes SDA only while SCL is low, so its own data never forms a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_q | output | 56 | All seven registers, register i in bits 8i+7..8i |

## Verification
The hardest situation to reach is a transfer cut short. Two cases matter: a stop that lands partway through a data byte, and a repeated start that follows an index with no count. In both cases the partial byte must leave no trace, and the next transfer must decode cleanly. The bench builds these from its bit-level tasks, stopping after half a byte or issuing a start right after an index. It then reads the whole bank back. Random block writes with random start indices and counts push the index past the last register, and every write is read back to cover the 0xFF fill and the masked bits.

// File: rtl/smb_blkreg_pkg.sv
package smb_blkreg_pkg;
  localparam int          NREG_DEF = 7;
  localparam logic [6:0]  ADDR_DEF = 7'h6A;
  localparam logic [NREG_DEF*8-1:0] RST_DEF =
    {8'h21, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hCF, 8'h1C};
  localparam logic [NREG_DEF*8-1:0] WMASK_DEF =
    {8'h00, 8'h0F, 8'hFF, 8'hFF, 8'h7F, 8'hCC, 8'hFF};

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_INDEX, S_COUNT, S_WDATA, S_RCOUNT, S_RDATA
  } smb_state_e;
endpackage

// File: rtl/smb_blkreg_sync.sv
module smb_blkreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_blkreg_bank.sv
module smb_blkreg_bank #(
  parameter int               NREG  = smb_blkreg_pkg::NREG_DEF,
  parameter logic [NREG*8-1:0] RST   = smb_blkreg_pkg::RST_DEF,
  parameter logic [NREG*8-1:0] WMASK = smb_blkreg_pkg::WMASK_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_idx,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] cfg_q
);
  logic [7:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] M = WMASK[i*8 +: 8];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= RST[i*8 +: 8];
      else if (wr_en && wr_idx == 8'(i))
        regs[i] <= (regs[i] & ~M) | (wr_data & M);
    end
    assign cfg_q[i*8 +: 8] = regs[i];
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == 8'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/smb_blkreg_engine.sv
module smb_blkreg_engine
  import smb_blkreg_pkg::*;
#(
  parameter logic [6:0] ADDR    = ADDR_DEF,
  parameter logic [7:0] CNT_RST = 8'(NREG_DEF)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  smb_state_e state;
  logic [3:0] bitcnt;
  logic [7:0] rx, tx, idx, cnt;
  logic       sending, host_nack, load_cnt;
  logic [7:0] next_tx;

  assign rd_idx   = idx;
  assign load_cnt = (state == S_RCOUNT) && !sending;
  assign next_tx  = load_cnt ? cnt : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      bitcnt    <= '0;
      rx        <= '0;
      tx        <= '0;
      idx       <= '0;
      cnt       <= CNT_RST;
      sending   <= 1'b0;
      host_nack <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state <= S_IDLE; bitcnt <= '0; sending <= 1'b0; sda_oe <= 1'b0;
      end else if (start_det) begin
        state <= S_ADDR; bitcnt <= '0; sending <= 1'b0; sda_oe <= 1'b0;
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            rx     <= {rx[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (bitcnt == 4'd8) begin
            host_nack <= sda_s;
            bitcnt    <= 4'd9;
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            if (sending) sda_oe <= 1'b0;
            else begin
              case (state)
                S_ADDR: begin
                  if (rx[7:1] == ADDR) begin
                    sda_oe <= 1'b1;
                    state  <= rx[0] ? S_RCOUNT : S_INDEX;
                  end else state <= S_IDLE;
                end
                S_INDEX: begin idx <= rx; sda_oe <= 1'b1; state <= S_COUNT; end
                S_COUNT: begin cnt <= rx; sda_oe <= 1'b1; state <= S_WDATA; end
                S_WDATA: begin
                  wr_en <= 1'b1; wr_idx <= idx; wr_data <= rx;
                  idx <= idx + 8'd1; sda_oe <= 1'b1;
                end
                default: sda_oe <= 1'b0;
              endcase
            end
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            if (state == S_RCOUNT || state == S_RDATA) begin
              if (sending && host_nack) begin
                state <= S_IDLE; sending <= 1'b0;
              end else begin
                tx      <= next_tx;
                sda_oe  <= ~next_tx[7];
                sending <= 1'b1;
                if (!load_cnt) begin
                  idx   <= idx + 8'd1;
                  state <= S_RDATA;
                end
              end
            end
          end else if (sending && bitcnt != 4'd0) begin
            sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end
  end
endmodule

// File: rtl/smb_blkreg.sv
module smb_blkreg
  import smb_blkreg_pkg::*;
#(
  parameter int                NREG  = NREG_DEF,
  parameter logic [6:0]        ADDR  = ADDR_DEF,
  parameter logic [NREG*8-1:0] RST   = RST_DEF,
  parameter logic [NREG*8-1:0] WMASK = WMASK_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_q
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;

  smb_blkreg_sync #(.STAGES(2)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i, .scl_s, .sda_s,
    .scl_rise, .scl_fall, .start_det, .stop_det
  );

  smb_blkreg_engine #(.ADDR(ADDR), .CNT_RST(8'(NREG))) u_engine (
    .clk, .rst_n, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
    .rd_data, .rd_idx, .wr_en, .wr_idx, .wr_data, .sda_oe
  );

  smb_blkreg_bank #(.NREG(NREG), .RST(RST), .WMASK(WMASK)) u_bank (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_data, .rd_idx, .rd_data, .cfg_q
  );
endmodule

// File: rtl/smb_blkreg_chk.sv
module smb_blkreg_chk #(
  parameter int          W     = 56,
  parameter logic [W-1:0] WMASK = '1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_s,
  input logic         start_det,
  input logic         stop_det,
  input logic         sda_oe,
  input logic         wr_en,
  input logic [W-1:0] cfg_q
);
  // R8: stop releases the data line on the next cycle
  a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  // R8: a start also releases the line before the address phase
  a_r8_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
  // R6: bits outside the write mask never move
  a_r6_ro_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg_q & ~WMASK));
  // R9: target data moves only while SCL is low
  a_r9_sda_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);
  // R2: one register strobe per data byte
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

bind smb_blkreg smb_blkreg_chk #(.W(NREG*8), .WMASK(WMASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .wr_en(wr_en), .cfg_q(cfg_q)
);

// File: tb/smb_blkreg_bench.sv
module smb_blkreg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_h = 1'b1;
  logic sda_oe;
  logic [55:0] cfg_q;
  logic line;
  assign line = sda_h & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_blkreg u_smb_blkreg (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line),
    .sda_oe(sda_oe), .cfg_q(cfg_q)
  );

  int nchk = 0, nfail = 0;
  logic [7:0] exp_r [7];
  logic [7:0] exp_cnt;
  logic [7:0] wdat [16];
  localparam logic [7:0] MSK [7] = '{8'hFF, 8'hCC, 8'h7F, 8'hFF, 8'hFF, 8'h0F, 8'h00};
  localparam logic [7:0] RSV [7] = '{8'h1C, 8'hCF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h21};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] i);
    return (i < 8'd7) ? exp_r[i] : 8'hFF;
  endfunction

  function automatic void m_write(input logic [7:0] i, input logic [7:0] v);
    if (i < 8'd7) exp_r[i] = (exp_r[i] & ~MSK[i]) | (v & MSK[i]);
  endfunction

  function automatic logic [55:0] m_pack();
    logic [55:0] p;
    for (int i = 0; i < 7; i++) p[i*8 +: 8] = exp_r[i];
    return p;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    scl = 1'b0; cyc(H/2); sda_h = 1'b1; cyc(H/2);
    scl = 1'b1; cyc(H); sda_h = 1'b0; cyc(H);
  endtask

  task automatic bstop();
    scl = 1'b0; cyc(H/2); sda_h = 1'b0; cyc(H/2);
    scl = 1'b1; cyc(H); sda_h = 1'b1; cyc(H);
  endtask

  task automatic wbits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      scl = 1'b0; cyc(H/2); sda_h = b[i]; cyc(H/2);
      scl = 1'b1; cyc(H);
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    wbits(b, 8);
    scl = 1'b0; cyc(H/2); sda_h = 1'b1; cyc(H/2);
    scl = 1'b1; cyc(H/2); ack = ~line; cyc(H/2);
  endtask

  task automatic rbyte(input logic hack, output logic [7:0] b);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; cyc(2); sda_h = 1'b1; cyc(H-2);
      scl = 1'b1; cyc(H/2); s1 = line; cyc(H/2); s2 = line;
      b[i] = s1;
      chk(s1 == s2, "R9 data stable while SCL high", 64'(s2), 64'(s1));
    end
    scl = 1'b0; cyc(H/2); sda_h = ~hack; cyc(H/2);
    scl = 1'b1; cyc(H);
  endtask

  task automatic blk_write(input logic [7:0] n, input int x, input int nd);
    logic a;
    bstart();
    wbyte(8'hD4, a); chk(a, "R1 write address ack", 64'(a), 64'd1);
    wbyte(n, a);     chk(a, "R2 index ack", 64'(a), 64'd1);
    wbyte(8'(x), a); chk(a, "R2 count ack", 64'(a), 64'd1);
    exp_cnt = 8'(x);
    for (int j = 0; j < nd; j++) begin
      wbyte(wdat[j], a); chk(a, "R2 data ack", 64'(a), 64'd1);
      m_write(n + 8'(j), wdat[j]);
    end
    bstop();
    chk(cfg_q == m_pack(), "R6 bank after write", 64'(cfg_q), 64'(m_pack()));
  endtask

  task automatic blk_read(input logic [7:0] n, input int m);
    logic a;
    logic [7:0] b;
    bstart();
    wbyte(8'hD4, a); chk(a, "R1 address ack", 64'(a), 64'd1);
    wbyte(n, a);     chk(a, "R4 index ack", 64'(a), 64'd1);
    bstart();
    wbyte(8'hD5, a); chk(a, "R1 read address ack", 64'(a), 64'd1);
    rbyte(1'b1, b);  chk(b == exp_cnt, "R3 count returned", 64'(b), 64'(exp_cnt));
    for (int j = 0; j < m; j++) begin
      rbyte(j != m - 1, b);
      if (n + 8'(j) >= 8'd7)
        chk(b == 8'hFF, "R7 beyond last register", 64'(b), 64'hFF);
      else
        chk(b == m_read(n + 8'(j)), "R4 register byte", 64'(b), 64'(m_read(n + 8'(j))));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    void'($urandom(32'd7301));
    for (int i = 0; i < 7; i++) exp_r[i] = RSV[i];
    exp_cnt = 8'd7;
    cyc(5); rst_n = 1'b1; cyc(5);

    chk(cfg_q == m_pack(), "R6 reset values", 64'(cfg_q), 64'(m_pack()));
    chk(sda_oe == 1'b0, "R8 released after reset", 64'(sda_oe), 64'd0);

    // reset count and full bank read
    blk_read(8'd0, 7); bstop();

    // wrong address: no ack, rest ignored
    bstart();
    wbyte(8'hA6, a); chk(!a, "R1 foreign address not acked", 64'(a), 64'd0);
    wbyte(8'h00, a); chk(!a, "R1 ignored after mismatch", 64'(a), 64'd0);
    wbyte(8'h01, a); chk(!a, "R1 ignored after mismatch", 64'(a), 64'd0);
    wbyte(8'h55, a); chk(!a, "R1 ignored after mismatch", 64'(a), 64'd0);
    bstop();
    chk(cfg_q == m_pack(), "R1 bank untouched", 64'(cfg_q), 64'(m_pack()));

    // clear every register: read-only bits hold
    for (int j = 0; j < 7; j++) wdat[j] = 8'h00;
    blk_write(8'd0, 7, 7);
    blk_read(8'd0, 7); bstop();

    // past the end: index 6 onward, extra bytes beyond count
    wdat[0] = 8'hA5; wdat[1] = 8'h3C; wdat[2] = 8'h99; wdat[3] = 8'h11;
    blk_write(8'd6, 2, 4);
    blk_read(8'd5, 4); bstop();

    // stop inside a data byte
    bstart();
    wbyte(8'hD4, a); wbyte(8'd3, a); wbyte(8'd2, a);
    exp_cnt = 8'd2;
    wbyte(8'h5A, a); chk(a, "R8 byte before abort acked", 64'(a), 64'd1);
    m_write(8'd3, 8'h5A);
    wbits(8'hF0, 4);
    bstop();
    chk(cfg_q == m_pack(), "R8 partial byte dropped", 64'(cfg_q), 64'(m_pack()));
    blk_read(8'd3, 2); bstop();

    // start right after an index, then a fresh write
    bstart();
    wbyte(8'hD4, a); wbyte(8'd4, a);
    bstart();
    wbyte(8'hD4, a); chk(a, "R8 restart address ack", 64'(a), 64'd1);
    wbyte(8'd0, a); wbyte(8'd1, a);
    exp_cnt = 8'd1;
    wbyte(8'h77, a); m_write(8'd0, 8'h77);
    bstop();
    chk(cfg_q == m_pack(), "R8 write after restart", 64'(cfg_q), 64'(m_pack()));

    // after host nack the line stays free
    blk_read(8'd0, 2);
    for (int k = 0; k < 9; k++) begin
      scl = 1'b0; cyc(H); scl = 1'b1; cyc(H/2);
      chk(line == 1'b1, "R5 released after host nack", 64'(line), 64'd1);
      cyc(H/2);
    end
    bstop();
    chk(sda_oe == 1'b0, "R8 released after stop", 64'(sda_oe), 64'd0);

    // random block writes and read-backs
    for (int it = 0; it < 30; it++) begin
      logic [7:0] n;
      int x;
      n = 8'($urandom % 9);
      x = 1 + int'($urandom % 5);
      for (int j = 0; j < x; j++) wdat[j] = 8'($urandom);
      blk_write(n, x, x);
      blk_read(n, x); bstop();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule